// File: doc/BRIEF.md
# Data Access Watch Unit

This unit sits between a processor's load/store pipeline and the data bus. It inspects every data access for debug and protection purposes. The incoming address is first relocated by a process identifier: when software has loaded a non-zero process field and the access falls in the lowest address slot, the process field is merged into the top address bits. The relocated address goes to the bus combinationally.

The relocated address is then checked in two ways. If alignment checking is enabled, an access that is not word aligned raises a data abort. The address is also compared against two programmable data breakpoints. Each breakpoint is qualified by the kind of access it should catch. An alternative mode turns the second breakpoint register into an inverse mask for the first. On a breakpoint hit, the unit writes a data-breakpoint cause code into its debug status register and pulses a hit flag. While the status register's halt bit is set, breakpoint checking is suspended.

Software loads the configuration through a simple select/write port. Abort and hit are registered flags, valid in the cycle after the access strobe.

Top module: `dwatch_checker`

## Requirements
- R1: After a synchronous active-low reset, all configuration and status registers are zero. The abort and hit outputs are 0, the status output reads 0, and addresses pass through unrelocated.
- R2: `out_addr` equals `acc_addr` with the stored process field ORed into bits [31:25]. This happens only when that field (`cfg_wdata[31:25]` written with select 0) is non-zero and `acc_addr[31:25]` is zero. Otherwise `out_addr` equals `acc_addr`. The path is combinational.
- R3: With the alignment-enable bit set (bit 1 of the control register, select 1), a strobed access whose address has a non-zero bits [1:0] sets `abort_o` in the following cycle. With the bit clear, no abort is raised.
- R4: A breakpoint enable code of 0 never hits. Code 1 hits stores only, code 2 hits loads and stores, and code 3 hits loads only.
- R5: In normal mode (breakpoint-control bit 8 clear, select 4), breakpoint address 0 (select 2) and breakpoint address 1 (select 3) are independent. Each compares against the relocated address bits [31:2]. Breakpoint 0 is qualified by breakpoint-control bits [1:0], and breakpoint 1 by bits [3:2].
- R6: In mask mode (breakpoint-control bit 8 set), a hit occurs when the relocated address equals breakpoint address 0 in every bit where breakpoint address 1 is zero. The hit is qualified by bits [1:0] only; bits [3:2] have no effect.
- R7: A hit sets `bkpt_hit_o` for one cycle, in the cycle after the strobe. In the same cycle, status bits [4:2] read 3'b010 and all other status bits are unchanged.
- R8: While status bit 31 is set (status is written with select 5), no breakpoint hits and the status register is not modified by accesses.
- R9: Without a strobe, `abort_o` and `bkpt_hit_o` are 0 in the following cycle. A register write affects accesses starting the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Data access strobe |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access address from the pipeline |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Register select: 0 process, 1 control, 2 bp addr 0, 3 bp addr 1, 4 bp control, 5 status |
| cfg_wdata | input | 32 | Configuration write data |
| out_addr | output | 32 | Relocated address to the bus |
| abort_o | output | 1 | Alignment abort, one cycle after the strobe |
| bkpt_hit_o | output | 1 | Data breakpoint hit, one cycle after the strobe |
| status_o | output | 32 | Debug status register |

## Verification
A corrupted process field shows up as a wrong `out_addr` in the same cycle as the access. A wrong breakpoint register or enable code shows up as a missing or spurious `bkpt_hit_o` one cycle after the first access that exercises it. A corrupted status register is visible on `status_o` right away, and its halt bit silently masks hits from then on. The bench therefore checks `out_addr` before every edge, and checks `abort_o`, `bkpt_hit_o` and `status_o` after every edge. Directed cases cover each enable code, both compare modes and the halt bit, followed by a long mixed random sequence.

// File: rtl/dwatch_pkg.sv
// Shared constants for the data access watch unit.
// Assumes a 3-bit register select and a fixed cause code layout.
package dwatch_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_PID    = 3'd0,
        SEL_CTRL   = 3'd1,
        SEL_BPA0   = 3'd2,
        SEL_BPA1   = 3'd3,
        SEL_BPCTL  = 3'd4,
        SEL_STATUS = 3'd5
    } cfg_sel_e;

    localparam int        CTRL_ALIGN_BIT = 1;
    localparam int        BPCTL_MASK_BIT = 8;
    localparam int        CODE_W         = 2;
    localparam int        NUM_BP         = 2;
    localparam int        MOE_LSB        = 2;
    localparam int        MOE_W          = 3;
    localparam logic [2:0] MOE_DBRK      = 3'b010;

    typedef struct packed {
        logic                          mask_mode;
        logic [NUM_BP-1:0][CODE_W-1:0] code;
    } bpctl_t;
endpackage

// File: rtl/dwatch_regs.sv
// Configuration and debug status registers.
// Assumes writes and the hit update can coincide; the hit overlays the cause field.
module dwatch_regs
    import dwatch_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PID_LSB = 25
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [SEL_W-1:0]              sel,
    input  logic [ADDR_W-1:0]             wdata,
    input  logic                          hit_set,
    output logic [ADDR_W-1:PID_LSB]       pid,
    output logic                          align_en,
    output logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr,
    output bpctl_t                        bpctl,
    output logic [ADDR_W-1:0]             status
);
    // Load the configuration registers from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid      <= '0;
            align_en <= 1'b0;
            bp_addr  <= '0;
            bpctl    <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_PID:   pid <= wdata[ADDR_W-1:PID_LSB];
                SEL_CTRL:  align_en <= wdata[CTRL_ALIGN_BIT];
                SEL_BPA0:  bp_addr[0] <= wdata;
                SEL_BPA1:  bp_addr[1] <= wdata;
                SEL_BPCTL: begin
                    bpctl.code      <= wdata[NUM_BP*CODE_W-1:0];
                    bpctl.mask_mode <= wdata[BPCTL_MASK_BIT];
                end
                default: ;
            endcase
        end
    end

    // Debug status: software write, then breakpoint cause overlay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            if (we && cfg_sel_e'(sel) == SEL_STATUS)
                status <= wdata;
            if (hit_set)
                status[MOE_LSB+MOE_W-1:MOE_LSB] <= MOE_DBRK;
        end
    end

    // R7: a hit leaves the data-breakpoint code in the cause field
    p_moe_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> status[MOE_LSB+MOE_W-1:MOE_LSB] == MOE_DBRK);
endmodule

// File: rtl/dwatch_reloc.sv
// Process-ID relocation and misalignment detection; purely combinational.
// Assumes the process field occupies the address bits from PID_LSB upward.
module dwatch_reloc #(
    parameter int ADDR_W  = 32,
    parameter int PID_LSB = 25
) (
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic [ADDR_W-1:PID_LSB] pid,
    output logic [ADDR_W-1:0]       addr_out,
    output logic                    misaligned
);
    logic low_slot;

    // Merge the process field into addresses of the lowest slot.
    always_comb begin
        low_slot = (addr_in[ADDR_W-1:PID_LSB] == '0);
        addr_out = addr_in;
        if (low_slot && (pid != '0))
            addr_out[ADDR_W-1:PID_LSB] = pid;
        misaligned = (addr_out[1:0] != 2'b00);
    end

    // R2: relocation never touches the bits below the process field
    always_comb begin
        p_low_bits_kept_r2: assert (addr_out[PID_LSB-1:0] == addr_in[PID_LSB-1:0]);
    end
endmodule

// File: rtl/dwatch_bkpt.sv
// Data breakpoint comparators: two word comparators or one masked comparator.
// Assumes code 1 = stores, 2 = both, 3 = loads, 0 = off.
module dwatch_bkpt
    import dwatch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          is_store,
    input  logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr,
    input  bpctl_t                        bpctl,
    output logic                          match
);
    logic [NUM_BP-1:0] qual;
    logic [NUM_BP-1:0] word_hit;
    logic              mask_hit;

    // Per-breakpoint access-type qualification and word compare.
    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        always_comb begin
            unique case (bpctl.code[g])
                2'd1:    qual[g] = is_store;
                2'd2:    qual[g] = 1'b1;
                2'd3:    qual[g] = !is_store;
                default: qual[g] = 1'b0;
            endcase
            word_hit[g] = qual[g] && (addr[ADDR_W-1:2] == bp_addr[g][ADDR_W-1:2]);
        end
    end

    // Select between masked compare and independent word compares.
    always_comb begin
        mask_hit = qual[0] && (((addr ^ bp_addr[0]) & ~bp_addr[1]) == '0);
        match    = bpctl.mask_mode ? mask_hit : (|word_hit);
    end

    // R6: in mask mode a disabled breakpoint 0 never matches
    always_comb begin
        p_mask_off_r6: assert (!(bpctl.mask_mode && bpctl.code[0] == 2'd0 && match));
    end
endmodule

// File: rtl/dwatch_checker.sv
// Top of the data access watch unit: relocation, alignment abort, breakpoints.
// Assumes one access per strobe; abort and hit are registered, out_addr is not.
module dwatch_checker
    import dwatch_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PID_LSB = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] out_addr,
    output logic              abort_o,
    output logic              bkpt_hit_o,
    output logic [ADDR_W-1:0] status_o
);
    logic [ADDR_W-1:PID_LSB]       pid;
    logic                          align_en;
    logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
    bpctl_t                        bpctl;
    logic                          misaligned;
    logic                          match;
    logic                          hit_set;

    dwatch_regs #(.ADDR_W(ADDR_W), .PID_LSB(PID_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .hit_set(hit_set), .pid(pid), .align_en(align_en), .bp_addr(bp_addr),
        .bpctl(bpctl), .status(status_o)
    );

    dwatch_reloc #(.ADDR_W(ADDR_W), .PID_LSB(PID_LSB)) u_reloc (
        .addr_in(acc_addr), .pid(pid), .addr_out(out_addr), .misaligned(misaligned)
    );

    dwatch_bkpt #(.ADDR_W(ADDR_W)) u_bkpt (
        .addr(out_addr), .is_store(acc_store), .bp_addr(bp_addr),
        .bpctl(bpctl), .match(match)
    );

    // Breakpoints are suspended while the status halt bit is set.
    always_comb hit_set = acc_valid && !status_o[ADDR_W-1] && match;

    // Register the abort and hit flags for the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_o    <= 1'b0;
            bkpt_hit_o <= 1'b0;
        end else begin
            abort_o    <= acc_valid && align_en && misaligned;
            bkpt_hit_o <= hit_set;
        end
    end

    // R9: a hit always follows a strobe
    p_hit_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_hit_o |-> $past(acc_valid));
    // R3: an abort always follows a misaligned strobe
    p_abort_misaligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(acc_valid && acc_addr[1:0] != 2'b00));
    // R8: no hit while the halt bit was set
    p_halt_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_hit_o |-> !$past(status_o[ADDR_W-1]));
    // R8: accesses leave a halted status untouched
    p_halt_status_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ADDR_W-1] && !cfg_we) |=> $stable(status_o));
endmodule

// File: tb/tb_dwatch_checker.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module tb_dwatch_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_store = 1'b0, cfg_we = 1'b0;
    logic [31:0] acc_addr = '0, cfg_wdata = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] out_addr, status_o;
    logic        abort_o, bkpt_hit_o;

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    logic [31:0] m_pid, m_ctrl, m_b0, m_b1, m_bpc, m_stat;
    bit          e_abort, e_hit;

    dwatch_checker dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_addr(acc_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .out_addr(out_addr), .abort_o(abort_o), .bkpt_hit_o(bkpt_hit_o), .status_o(status_o)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        finish_run();
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_reloc(logic [31:0] a);
        if (a[31:25] == 7'd0 && m_pid[31:25] != 7'd0) return a | {m_pid[31:25], 25'd0};
        return a;
    endfunction

    function automatic bit m_qual(logic [1:0] c, bit st);
        if (c == 2'd0) return 0;
        if (c == 2'd2) return 1;
        return (c == 2'd1) ? st : !st;
    endfunction

    function automatic bit m_match(logic [31:0] a, bit st);
        if (m_bpc[8]) return m_qual(m_bpc[1:0], st) && (((a ^ m_b0) & ~m_b1) == 32'd0);
        return (m_qual(m_bpc[1:0], st) && (a >> 2) == (m_b0 >> 2)) ||
               (m_qual(m_bpc[3:2], st) && (a >> 2) == (m_b1 >> 2));
    endfunction

    // One cycle: drive at the falling edge, check the bus address, clock, check flags.
    task automatic step(bit v, bit st, logic [31:0] a, bit we, logic [2:0] sel,
                        logic [31:0] d, string tag);
        logic [31:0] ra;
        acc_valid = v; acc_store = st; acc_addr = a;
        cfg_we = we; cfg_sel = sel; cfg_wdata = d;
        #1;
        ra = m_reloc(a);
        chk({tag, " R2 out_addr"}, out_addr, ra);
        @(posedge clk);
        e_abort = v && m_ctrl[1] && (ra[1:0] != 2'b00);
        e_hit   = v && !m_stat[31] && m_match(ra, st);
        if (we) begin
            case (sel)
                3'd0: m_pid = d;
                3'd1: m_ctrl = d;
                3'd2: m_b0 = d;
                3'd3: m_b1 = d;
                3'd4: m_bpc = d;
                3'd5: m_stat = d;
                default: ;
            endcase
        end
        if (e_hit) m_stat[4:2] = 3'b010;
        @(negedge clk);
        chk({tag, " R3 abort"}, {31'd0, abort_o}, {31'd0, e_abort});
        chk({tag, " R7 hit"}, {31'd0, bkpt_hit_o}, {31'd0, e_hit});
        chk({tag, " R7 status"}, status_o, m_stat);
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        step(0, 0, 32'h0, 1, sel, d, "R9 write");
    endtask

    task automatic acc(bit st, logic [31:0] a, string tag);
        step(1, st, a, 0, 3'd0, 32'h0, tag);
    endtask

    initial begin
        m_pid = 0; m_ctrl = 0; m_b0 = 0; m_b1 = 0; m_bpc = 0; m_stat = 0;
        acc_valid = 1; acc_addr = 32'h0000_0006; acc_store = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 abort after reset", {31'd0, abort_o}, 32'd0);
        chk("R1 hit after reset", {31'd0, bkpt_hit_o}, 32'd0);
        chk("R1 status after reset", status_o, 32'd0);
        chk("R1 no relocation", out_addr, 32'h0000_0006);
        rst_n = 1;
        acc(1, 32'h0000_0006, "R1 unconfigured access");

        // relocation
        wr(3'd0, 32'h0A00_0000);
        acc(0, 32'h0000_1000, "R2 low slot");
        chk("R2 explicit relocation", out_addr, 32'h0A00_1000);
        acc(0, 32'h4000_1000, "R2 high slot");
        chk("R2 high slot unchanged", out_addr, 32'h4000_1000);
        wr(3'd0, 32'h0);

        // alignment
        acc(0, 32'h0000_0002, "R3 disabled");
        wr(3'd1, 32'h2);
        acc(0, 32'h0000_0002, "R3 misaligned");
        chk("R3 abort raised", {31'd0, abort_o}, 32'd1);
        acc(1, 32'h0000_0004, "R3 aligned");
        step(0, 0, 32'h3, 0, 3'd0, 32'h0, "R9 no strobe");
        wr(3'd1, 32'h0);

        // enable codes, normal mode, breakpoint 0 and 1
        wr(3'd2, 32'h0000_1000);
        wr(3'd3, 32'h0000_2000);
        for (int c = 0; c < 4; c++) begin
            wr(3'd4, c);
            acc(1, 32'h0000_1003, "R4 bp0 store");
            acc(0, 32'h0000_1001, "R4 bp0 load");
            wr(3'd4, c << 2);
            acc(1, 32'h0000_2002, "R5 bp1 store");
            acc(0, 32'h0000_2000, "R5 bp1 load");
        end
        wr(3'd4, 32'h2);
        acc(0, 32'h0000_1004, "R5 next word misses");
        acc(0, 32'h0000_1000, "R5 hit");
        chk("R7 cause field", {29'd0, status_o[4:2]}, 32'd2);

        // mask mode
        wr(3'd2, 32'h0000_5000);
        wr(3'd3, 32'h0000_00FF);
        wr(3'd4, 32'h102);
        acc(0, 32'h0000_50AB, "R6 masked hit");
        chk("R6 masked hit flag", {31'd0, bkpt_hit_o}, 32'd1);
        acc(0, 32'h0000_5100, "R6 masked miss");
        wr(3'd4, 32'h10C);
        acc(0, 32'h0000_00FF, "R6 bp1 code ignored");
        acc(0, 32'h0000_5000, "R6 code0 off");

        // status field and halt
        wr(3'd4, 32'h002);
        wr(3'd5, 32'h0000_001F);
        acc(0, 32'h0000_5000, "R7 overlay");
        chk("R7 other bits kept", status_o, 32'h0000_000B);
        wr(3'd5, 32'h8000_0000);
        acc(0, 32'h0000_5000, "R8 halted");
        chk("R8 status untouched", status_o, 32'h8000_0000);
        wr(3'd5, 32'h0);

        // write and access in the same cycle: the write takes effect next cycle
        step(1, 0, 32'h0000_7000, 1, 3'd2, 32'h0000_7000, "R9 same-cycle write");
        acc(0, 32'h0000_7000, "R9 after write");

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            bit          v = ($urandom % 4) != 0;
            bit          w = ($urandom % 6) == 0;
            logic [2:0]  s = 3'($urandom % 6);
            logic [31:0] d = $urandom;
            logic [31:0] a = {($urandom % 3 == 0) ? 7'd0 : 7'($urandom),
                              13'd0, 8'($urandom % 4), 4'($urandom)};
            if (s == 3'd4) d = d & 32'h10F;
            if (s == 3'd5) d = d & 32'h8000_00FF;
            if (s == 3'd2 || s == 3'd3) d = {d[31:25], 13'd0, d[11:0]};
            step(v, 1'($urandom), a, w, s, d, "R4 R5 R6 random");
        end

        finish_run();
    end
endmodule